// File: doc/BRIEF.md
# Two-Client Memory Request Arbiter

This block lets a writer and a reader share one memory controller that accepts a single request at a time. It waits until the controller reports that its start-up sequence is done. From then on it looks at both clients' request inputs in every idle cycle. When only one client is asking, that client wins. When both are asking, the reader wins. When neither is asking, the block looks again on the next cycle.

When a client wins, the block registers that client's address and whether the access is a read or a write. It then shows one request to the controller and holds it unchanged until the controller accepts it. The winning client keeps the controller until the controller signals the end of its burst. During the burst, the controller's write-data take strobe, its read-data valid strobe and its burst-end strobe reach only the winning client. The other client sees all of them low.

Each client request is a valid/ready handshake. A client holds `*_req_valid` and its address steady until it sees `*_req_ready` high in the same cycle, and the request is accepted at that clock edge. Ready is never high for both clients at once, and is only high while the block is polling. The block drops ready as soon as a grant is made. The request towards the controller follows the same rule: `mem_req_valid` stays high with a stable address and type until `mem_req_ready` is seen high at an edge.

Top module: `mem_req_arbiter`

## Requirements
- R1: Until `mem_init_done` has been high at a clock edge after reset, neither client ready nor `mem_req_valid` is ever asserted, whatever the clients request.
- R2: While polling, a client that is the only one requesting sees its ready high in that same cycle.
- R3: When both clients request in the same polling cycle, only `rd_req_ready` is high, so the reader is granted.
- R4: With no request pending, the block keeps polling: no grant is made and `mem_req_valid` stays low. A request that arrives in a later cycle is granted in the cycle it arrives.
- R5: Starting the cycle after a grant, `mem_req_valid` is high. It stays high with unchanged `mem_req_addr` and `mem_req_write` until `mem_req_ready` is seen at an edge. `mem_req_write` is 1 for the writer and 0 for the reader.
- R6: At most one client ready is high in any cycle, and neither is high from the grant until the burst ends, even if both clients request.
- R7: While a client owns the controller, `mem_wdata_take`, `mem_rdata_valid` and `mem_burst_end` reach only that client's `*_data_take`, `*_data_valid` or `*_burst_end` output. The other client's outputs stay 0.
- R8: `mem_wdata` equals `wr_data` while the writer owns the controller and is 0 while the reader owns it.
- R9: After the clock edge at which `mem_burst_end` is high, the block polls again in the very next cycle.
- R10: The address and type come from registers loaded at the grant. A client changing its address after the grant does not change `mem_req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_init_done | input | 1 | Controller start-up finished |
| rd_req_valid | input | 1 | Reader request valid |
| rd_req_addr | input | ADDR_W | Reader burst address |
| rd_req_ready | output | 1 | Reader request accepted this cycle |
| rd_data | output | DATA_W | Read data towards reader |
| rd_data_valid | output | 1 | Read word valid for reader |
| rd_burst_end | output | 1 | Reader burst finished |
| wr_req_valid | input | 1 | Writer request valid |
| wr_req_addr | input | ADDR_W | Writer burst address |
| wr_req_ready | output | 1 | Writer request accepted this cycle |
| wr_data | input | DATA_W | Write word from writer |
| wr_data_take | output | 1 | Writer's current word consumed |
| wr_burst_end | output | 1 | Writer burst finished |
| mem_req_valid | output | 1 | Request to controller |
| mem_req_ready | input | 1 | Controller accepts request |
| mem_req_write | output | 1 | 1 = write burst, 0 = read burst |
| mem_req_addr | output | ADDR_W | Registered burst address |
| mem_wdata | output | DATA_W | Write word towards controller |
| mem_wdata_take | input | 1 | Controller consumes a write word |
| mem_rdata | input | DATA_W | Read word from controller |
| mem_rdata_valid | input | 1 | Controller read word valid |
| mem_burst_end | input | 1 | Controller burst finished |

## Verification
The bench builds the block with `ADDR_W` = 8 and `DATA_W` = 16. With these small widths, every address and data value the bench drives can be written as a simple arithmetic pattern and checked exactly. The bench sweeps all four combinations of the two request inputs. For each combination it tries controller acceptance delays of 0 to 2 cycles and burst lengths of 1 to 8 words. This covers the single-cycle burst, requests held while the controller is slow to accept, and priority conflicts raised in the same cycle that a burst ends.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_INIT = 2'd0,
    ST_POLL      = 2'd1,
    ST_ISSUE     = 2'd2,
    ST_BURST     = 2'd3
  } arb_state_e;

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mem_arb_pick.sv
module mem_arb_pick #(
  parameter int unsigned N_PORTS = 2,
  localparam int unsigned IDX_W = mem_arb_pkg::idx_width(N_PORTS)
) (
  input  logic [N_PORTS-1:0] want,
  output logic               any_want,
  output logic [IDX_W-1:0]   win_idx,
  output logic [N_PORTS-1:0] win_onehot
);
  // lowest index has highest priority
  for (genvar g = 0; g < N_PORTS; g++) begin : g_oh
    if (g == 0) begin : g_first
      assign win_onehot[g] = want[g];
    end else begin : g_rest
      assign win_onehot[g] = want[g] & ~|want[g-1:0];
    end
  end

  assign any_want = |want;

  always_comb begin
    win_idx = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (want[i]) win_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mem_arb_fsm.sv
module mem_arb_fsm
  import mem_arb_pkg::*;
#(
  parameter int unsigned N_PORTS = 2,
  parameter int unsigned ADDR_W  = 22,
  localparam int unsigned IDX_W  = idx_width(N_PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              any_want,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [ADDR_W-1:0] win_addr,
  input  logic              win_write,
  input  logic              req_ready,
  input  logic              burst_end,
  output logic              polling,
  output logic              busy,
  output logic [IDX_W-1:0]  owner,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_write
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_INIT: if (init_done) state_d = ST_POLL;
      ST_POLL:      if (any_want)  state_d = ST_ISSUE;
      ST_ISSUE:     if (req_ready) state_d = ST_BURST;
      ST_BURST:     if (burst_end) state_d = ST_POLL;
      default:                     state_d = ST_WAIT_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_WAIT_INIT;
      owner     <= '0;
      req_addr  <= '0;
      req_write <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_POLL && any_want) begin
        owner     <= win_idx;
        req_addr  <= win_addr;
        req_write <= win_write;
      end
    end
  end

  assign polling   = (state_q == ST_POLL);
  assign req_valid = (state_q == ST_ISSUE);
  assign busy      = (state_q == ST_ISSUE) || (state_q == ST_BURST);
endmodule

// File: rtl/mem_arb_route.sv
module mem_arb_route #(
  parameter int unsigned N_PORTS = 2,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = mem_arb_pkg::idx_width(N_PORTS)
) (
  input  logic              busy,
  input  logic [IDX_W-1:0]  owner,
  input  logic [DATA_W-1:0] port_wdata [N_PORTS],
  input  logic              take_in,
  input  logic              rvalid_in,
  input  logic              end_in,
  output logic [DATA_W-1:0] wdata_out,
  output logic [N_PORTS-1:0] take_vec,
  output logic [N_PORTS-1:0] rvalid_vec,
  output logic [N_PORTS-1:0] end_vec
);
  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    logic mine;
    assign mine          = busy && (owner == IDX_W'(g));
    assign take_vec[g]   = mine & take_in;
    assign rvalid_vec[g] = mine & rvalid_in;
    assign end_vec[g]    = mine & end_in;
  end

  always_comb begin
    wdata_out = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (busy && owner == IDX_W'(i)) wdata_out = port_wdata[i];
    end
  end
endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter #(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_init_done,
  input  logic              rd_req_valid,
  input  logic [ADDR_W-1:0] rd_req_addr,
  output logic              rd_req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_valid,
  output logic              rd_burst_end,
  input  logic              wr_req_valid,
  input  logic [ADDR_W-1:0] wr_req_addr,
  output logic              wr_req_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_data_take,
  output logic              wr_burst_end,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_wdata_take,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdata_valid,
  input  logic              mem_burst_end
);
  // port order sets priority: index 0 wins
  localparam int unsigned N_PORTS = 2;
  localparam int unsigned P_RD    = 0;
  localparam int unsigned P_WR    = 1;
  localparam int unsigned IDX_W   = mem_arb_pkg::idx_width(N_PORTS);
  localparam logic [N_PORTS-1:0] WRITE_MASK = N_PORTS'(1) << P_WR;

  logic [N_PORTS-1:0] want, win_oh, take_vec, rvalid_vec, end_vec;
  logic [ADDR_W-1:0]  addr_arr  [N_PORTS];
  logic [DATA_W-1:0]  wdata_arr [N_PORTS];
  logic               any_want, polling, busy;
  logic [IDX_W-1:0]   win_idx, owner;

  assign want[P_RD]      = rd_req_valid;
  assign want[P_WR]      = wr_req_valid;
  assign addr_arr[P_RD]  = rd_req_addr;
  assign addr_arr[P_WR]  = wr_req_addr;
  assign wdata_arr[P_RD] = '0;
  assign wdata_arr[P_WR] = wr_data;

  mem_arb_pick #(.N_PORTS(N_PORTS)) u_pick (
    .want       (want),
    .any_want   (any_want),
    .win_idx    (win_idx),
    .win_onehot (win_oh)
  );

  mem_arb_fsm #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (mem_init_done),
    .any_want  (any_want),
    .win_idx   (win_idx),
    .win_addr  (addr_arr[win_idx]),
    .win_write (WRITE_MASK[win_idx]),
    .req_ready (mem_req_ready),
    .burst_end (mem_burst_end),
    .polling   (polling),
    .busy      (busy),
    .owner     (owner),
    .req_valid (mem_req_valid),
    .req_addr  (mem_req_addr),
    .req_write (mem_req_write)
  );

  mem_arb_route #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_route (
    .busy       (busy),
    .owner      (owner),
    .port_wdata (wdata_arr),
    .take_in    (mem_wdata_take),
    .rvalid_in  (mem_rdata_valid),
    .end_in     (mem_burst_end),
    .wdata_out  (mem_wdata),
    .take_vec   (take_vec),
    .rvalid_vec (rvalid_vec),
    .end_vec    (end_vec)
  );

  assign rd_req_ready  = polling & win_oh[P_RD];
  assign wr_req_ready  = polling & win_oh[P_WR];
  assign rd_data       = mem_rdata;
  assign rd_data_valid = rvalid_vec[P_RD];
  assign rd_burst_end  = end_vec[P_RD];
  assign wr_data_take  = take_vec[P_WR];
  assign wr_burst_end  = end_vec[P_WR];
endmodule

// File: rtl/mem_req_arbiter_chk.sv
module mem_req_arbiter_chk #(
  parameter int unsigned ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_init_done,
  input logic              rd_req_valid,
  input logic              wr_req_valid,
  input logic              rd_req_ready,
  input logic              wr_req_ready,
  input logic              rd_data_valid,
  input logic              wr_data_take,
  input logic              rd_burst_end,
  input logic              wr_burst_end,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr
);
  logic init_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) init_seen <= 1'b0;
    else if (mem_init_done) init_seen <= 1'b1;
  end

  // R1
  no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_seen |-> !mem_req_valid && !rd_req_ready && !wr_req_ready);

  // R3
  rd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && wr_req_valid && (rd_req_ready || wr_req_ready))
      |-> (rd_req_ready && !wr_req_ready));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready)
      |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_ready && wr_req_ready));

  // R6
  no_grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rd_req_ready && !wr_req_ready);

  // R7
  strobe_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_data_take && rd_data_valid) && !(wr_burst_end && rd_burst_end));
endmodule

bind mem_req_arbiter mem_req_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_init_done (mem_init_done),
  .rd_req_valid  (rd_req_valid),
  .wr_req_valid  (wr_req_valid),
  .rd_req_ready  (rd_req_ready),
  .wr_req_ready  (wr_req_ready),
  .rd_data_valid (rd_data_valid),
  .wr_data_take  (wr_data_take),
  .rd_burst_end  (rd_burst_end),
  .wr_burst_end  (wr_burst_end),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr)
);

// File: tb/test_mem_req_arbiter.sv
`timescale 1ns/1ps
module test_mem_req_arbiter;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_init_done = 1'b0;
  logic rd_req_valid = 1'b0, wr_req_valid = 1'b0;
  logic [AW-1:0] rd_req_addr = '0, wr_req_addr = '0;
  logic [DW-1:0] wr_data = '0, mem_rdata = '0;
  logic mem_req_ready = 1'b0, mem_wdata_take = 1'b0;
  logic mem_rdata_valid = 1'b0, mem_burst_end = 1'b0;
  logic rd_req_ready, rd_data_valid, rd_burst_end;
  logic wr_req_ready, wr_data_take, wr_burst_end;
  logic mem_req_valid, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] rd_data, mem_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mem_req_arbiter #(.ADDR_W(AW), .DATA_W(DW)) i_mem_req_arbiter (
    .clk(clk), .rst_n(rst_n), .mem_init_done(mem_init_done),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_ready(rd_req_ready),
    .rd_data(rd_data), .rd_data_valid(rd_data_valid), .rd_burst_end(rd_burst_end),
    .wr_req_valid(wr_req_valid), .wr_req_addr(wr_req_addr), .wr_req_ready(wr_req_ready),
    .wr_data(wr_data), .wr_data_take(wr_data_take), .wr_burst_end(wr_burst_end),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_wdata(mem_wdata), .mem_wdata_take(mem_wdata_take),
    .mem_rdata(mem_rdata), .mem_rdata_valid(mem_rdata_valid),
    .mem_burst_end(mem_burst_end)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic run_case(bit rv, bit wv, int lat, int blen, int seed);
    bit exp_rd, exp_wr;
    logic [AW-1:0] a_rd, a_wr, exp_addr;
    exp_rd = rv;
    exp_wr = wv && !rv;
    a_rd = AW'(seed * 3 + 1);
    a_wr = AW'(seed * 5 + 2);
    @(negedge clk);
    rd_req_valid = rv; wr_req_valid = wv;
    rd_req_addr = a_rd; wr_req_addr = a_wr;
    #1;
    chk("R2/R3 rd_req_ready", rd_req_ready, exp_rd);
    chk("R2/R3 wr_req_ready", wr_req_ready, exp_wr);
    if (!rv && !wv) begin
      @(negedge clk); #1;
      chk("R4 idle no req", mem_req_valid, 0);
      chk("R4 idle no grant", {rd_req_ready, wr_req_ready}, 0);
      return;
    end
    exp_addr = exp_rd ? a_rd : a_wr;
    @(negedge clk);
    // competing requests and moved addresses after grant
    rd_req_valid = 1'b1; wr_req_valid = 1'b1;
    rd_req_addr = ~a_rd; wr_req_addr = ~a_wr;
    #1;
    chk("R5 mem_req_valid", mem_req_valid, 1);
    chk("R10 mem_req_addr", mem_req_addr, exp_addr);
    chk("R5 mem_req_write", mem_req_write, exp_wr);
    chk("R6 no ready while busy", {rd_req_ready, wr_req_ready}, 0);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk); #1;
      chk("R5 held valid", mem_req_valid, 1);
      chk("R5 held addr", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int w = 0; w < blen; w++) begin
      wr_data = DW'(seed * 17 + w * 7 + 5);
      mem_rdata = DW'(seed * 11 + w);
      mem_wdata_take = 1'b1;
      mem_rdata_valid = 1'b1;
      mem_burst_end = (w == blen - 1);
      #1;
      chk("R5 req dropped", mem_req_valid, 0);
      chk("R6 no ready in burst", {rd_req_ready, wr_req_ready}, 0);
      chk("R7 wr_data_take", wr_data_take, exp_wr);
      chk("R7 rd_data_valid", rd_data_valid, exp_rd);
      chk("R7 wr_burst_end", wr_burst_end, exp_wr && (w == blen - 1));
      chk("R7 rd_burst_end", rd_burst_end, exp_rd && (w == blen - 1));
      chk("R8 mem_wdata", mem_wdata, exp_wr ? wr_data : '0);
      @(negedge clk);
      mem_wdata_take = 1'b0; mem_rdata_valid = 1'b0; mem_burst_end = 1'b0;
    end
    #1;
    chk("R9 repoll rd_req_ready", rd_req_ready, 1);
    chk("R9 repoll wr_req_ready", wr_req_ready, 0);
    rd_req_valid = 1'b0; wr_req_valid = 1'b0;
    #0.5;
    chk("R9 writer alone idle", wr_req_ready, 0);
  endtask

  initial begin
    rd_req_valid = 1'b1; wr_req_valid = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R1 no ready before init", {rd_req_ready, wr_req_ready}, 0);
      chk("R1 no mem req before init", mem_req_valid, 0);
    end
    rd_req_valid = 1'b0; wr_req_valid = 1'b0;
    mem_init_done = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      for (int lat = 0; lat < 3; lat++) begin
        for (int bl = 1; bl <= 8; bl++) begin
          run_case(s[0], s[1], lat, bl, s * 31 + lat * 9 + bl);
        end
      end
    end
    // writer alone straight after an idle poll (R4, R2)
    run_case(1'b0, 1'b0, 0, 1, 3);
    run_case(1'b0, 1'b1, 1, 8, 77);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got=%0d exp=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule